// File: doc/BRIEF.md
# Multithreaded Stage Skid-Buffer Controller

One pipeline stage serves several hardware threads. Instructions arrive from upstream with a payload, a sequence number, a thread number and a squashed marker. They are held in per-thread FIFO skid buffers that draw on one shared pool of capacity. One instruction per cycle leaves through a ready/valid port to the downstream stage.

Each thread runs its own status machine with five states. Per-thread stall and squash inputs drive the machine, and so does the thread's skid-buffer occupancy. The stage answers upstream with one-cycle block and unblock pulses for each thread. A squash carries a sequence bound and trims the head of the thread's buffer. Entries are removed from the head while they are younger than the bound, and trimming stops at the first entry that is not.

Top module: `skid_stage`

## Requirements
- R1: After reset every thread is in state Idle, every buffer is empty, `inReady` is 1, `outValid` is 0 and no pulse is raised. The state codes on `threadState` (3 bits per thread, thread 0 in the low bits) are Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R2: An incoming instruction whose `inSquashed` is 1 is dropped and never shows up at the output.
- R3: All thread buffers share a capacity of CAP entries. `inReady` is 1 exactly while the total occupancy is below CAP. An offer made while `inReady` is 0 is not stored.
- R4: Only a thread in Idle, Running or Unblocking, with no stall or squash this cycle, may drain. The stage sends at most one instruction per cycle, in FIFO order per thread. `outValid` is 0 while `resFail` is 1, and a transfer happens when `outValid` and `outReady` are both 1.
- R5: If a draining-state thread still holds entries after the cycle's drain, it moves to Blocked without a block pulse.
- R6: A stall on a thread that is not Blocked moves it to Blocked and raises its `blockPulse` for one cycle. A stall on a thread that is already Blocked raises no pulse.
- R7: With no stall, a Blocked thread goes to Running with a one-cycle `unblockPulse` if its buffer is empty, and to Unblocking otherwise. An Unblocking thread whose buffer becomes empty goes to Running with an `unblockPulse`.
- R8: A squash on a thread with bound S puts the thread in Squashing for the next cycle. It removes head entries while their sequence number is greater than S and stops at the first entry at or below S; entries behind that entry are kept.
- R9: A Squashing thread with no new squash or stall goes to Unblocking if its buffer is non-empty, and to Running if it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream offers an instruction |
| inReady | output | 1 | Shared pool has a free slot |
| inData | input | DATA_W | Instruction payload |
| inSeq | input | SEQ_W | Instruction sequence number |
| inTid | input | TID_W | Owning thread |
| inSquashed | input | 1 | Instruction already squashed upstream |
| outValid | output | 1 | Head instruction of the selected thread is offered |
| outReady | input | 1 | Downstream has room |
| outData | output | DATA_W | Payload sent downstream |
| outSeq | output | SEQ_W | Sequence number sent downstream |
| outTid | output | TID_W | Thread of the offered instruction |
| resFail | input | 1 | Resource request failed this cycle |
| stallIn | input | THREADS | Per-thread stall from later stages |
| squashIn | input | THREADS | Per-thread squash request |
| squashSeq | input | THREADS*SEQ_W | Per-thread squash bound |
| blockPulse | output | THREADS | Per-thread block pulse upstream |
| unblockPulse | output | THREADS | Per-thread unblock pulse upstream |
| threadState | output | THREADS*3 | Per-thread state code |

## Verification
The hardest case to reach is a squash whose scan stops early: the buffer head sits at or below the bound while a younger entry waits behind it. The stimulus holds `outReady` low so that nothing drains, fills the whole shared pool across both threads, and offers one extra instruction that must be refused. It then squashes both threads in the same cycle with different bounds. After that, a collection window drains everything and checks that the kept thread releases exactly its two entries in order, and that the flushed thread and the refused instruction never appear.

// File: rtl/skid_pkg.sv
package skid_pkg;
  localparam int MAX_THREADS = 8;
  localparam int SEL_W = $clog2(MAX_THREADS);

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_BLOCKED = 3'd2,
    ST_UNBLOCK = 3'd3,
    ST_SQUASH  = 3'd4
  } thrState_t;

  // Strobes from control to datapath, one bit per thread
  typedef struct packed {
    logic [MAX_THREADS-1:0] push;
    logic [MAX_THREADS-1:0] pop;
    logic [MAX_THREADS-1:0] flush;
    logic [SEL_W-1:0]       sel;
  } skidStrobe_t;
endpackage

// File: rtl/skid_datapath.sv
module skid_datapath
  import skid_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int CAP = 4,        // power of two, at least 2
  parameter int DATA_W = 16,
  parameter int SEQ_W = 8,
  localparam int CNT_W = $clog2(CAP) + 1,
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  skidStrobe_t                    strobe,
  input  logic [DATA_W-1:0]              inData,
  input  logic [SEQ_W-1:0]               inSeq,
  input  logic [THREADS*SEQ_W-1:0]       squashSeq,
  output logic [THREADS-1:0][CNT_W-1:0]  occ,
  output logic [CNT_W-1:0]               totalOcc,
  output logic [DATA_W-1:0]              outData,
  output logic [SEQ_W-1:0]               outSeq
);
  localparam int PW = $clog2(CAP);

  logic [DATA_W-1:0] headData [THREADS];
  logic [SEQ_W-1:0]  headSeq  [THREADS];
  logic unusedStrobe;
  assign unusedStrobe = ^strobe;

  for (genvar t = 0; t < THREADS; t++) begin : gThread
    logic [DATA_W-1:0] dataMem [CAP];
    logic [SEQ_W-1:0]  seqMem  [CAP];
    logic [PW-1:0]     head, tail, scanIdx;
    logic [CNT_W-1:0]  cnt, flushCnt, popAmt;
    logic              stopScan;
    logic [SEQ_W-1:0]  bound;

    assign bound = squashSeq[t*SEQ_W +: SEQ_W];

    // Count head entries younger than the bound, stop at the first older one
    always_comb begin
      flushCnt = '0;
      stopScan = 1'b0;
      scanIdx  = head;
      for (int i = 0; i < CAP; i++) begin
        scanIdx = head + PW'(i);
        if (!stopScan && (CNT_W'(i) < cnt)) begin
          if (seqMem[scanIdx] > bound) flushCnt = flushCnt + 1'b1;
          else stopScan = 1'b1;
        end
      end
    end

    assign popAmt = strobe.flush[t] ? flushCnt : CNT_W'(strobe.pop[t]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        head <= '0;
        tail <= '0;
        cnt  <= '0;
      end else begin
        if (strobe.push[t]) tail <= tail + 1'b1;
        head <= head + popAmt[PW-1:0];
        cnt  <= cnt + CNT_W'(strobe.push[t]) - popAmt;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.push[t]) begin
        dataMem[tail] <= inData;
        seqMem[tail]  <= inSeq;
      end
    end

    assign occ[t]      = cnt;
    assign headData[t] = dataMem[head];
    assign headSeq[t]  = seqMem[head];
  end

  always_comb begin
    totalOcc = '0;
    for (int t = 0; t < THREADS; t++) totalOcc = totalOcc + occ[t];
  end

  assign outData = headData[strobe.sel[TID_W-1:0]];
  assign outSeq  = headSeq[strobe.sel[TID_W-1:0]];
endmodule

// File: rtl/skid_control.sv
module skid_control
  import skid_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int CAP = 4,
  parameter int SEQ_W = 8,
  localparam int CNT_W = $clog2(CAP) + 1,
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [SEQ_W-1:0]              inSeq,
  input  logic [TID_W-1:0]              inTid,
  input  logic                          inSquashed,
  input  logic                          outReady,
  input  logic                          resFail,
  input  logic [THREADS-1:0]            stallIn,
  input  logic [THREADS-1:0]            squashIn,
  input  logic [THREADS*SEQ_W-1:0]      squashSeq,
  input  logic [THREADS-1:0][CNT_W-1:0] occ,
  input  logic [CNT_W-1:0]              totalOcc,
  output skidStrobe_t                   strobe,
  output logic                          inReady,
  output logic                          outValid,
  output logic [THREADS-1:0]            blockPulse,
  output logic [THREADS-1:0]            unblockPulse,
  output logic [THREADS-1:0][2:0]       stateOut
);
  thrState_t          state  [THREADS];
  thrState_t          nState [THREADS];
  logic [THREADS-1:0] nBp, nUbp, elig, push, pop;
  logic [SEL_W-1:0]   sel;
  logic               anyElig, dropSq, accept, fire;

  assign inReady = totalOcc < CNT_W'(CAP);
  // An arrival younger than its thread's squash bound dies with the squash
  assign dropSq  = squashIn[inTid] && (inSeq > squashSeq[inTid*SEQ_W +: SEQ_W]);
  assign accept  = inValid && inReady && !inSquashed && !dropSq;

  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      push[t] = accept && (inTid == TID_W'(t));
      elig[t] = !squashIn[t] && !stallIn[t] && (occ[t] != '0) &&
                (state[t] == ST_IDLE || state[t] == ST_RUN || state[t] == ST_UNBLOCK);
    end
  end

  // Lowest-numbered eligible thread owns the output this cycle
  always_comb begin
    sel = '0;
    anyElig = 1'b0;
    for (int t = THREADS - 1; t >= 0; t--) begin
      if (elig[t]) begin
        sel = SEL_W'(t);
        anyElig = 1'b1;
      end
    end
  end

  assign outValid = anyElig && !resFail;
  assign fire     = outValid && outReady;

  always_comb begin
    for (int t = 0; t < THREADS; t++) pop[t] = fire && (sel == SEL_W'(t));
  end

  always_comb begin
    strobe = '0;
    strobe.push[THREADS-1:0]  = push;
    strobe.pop[THREADS-1:0]   = pop;
    strobe.flush[THREADS-1:0] = squashIn;
    strobe.sel = sel;
  end

  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      nState[t] = state[t];
      nBp[t]    = 1'b0;
      nUbp[t]   = 1'b0;
      if (squashIn[t]) begin
        nState[t] = ST_SQUASH;
      end else if (stallIn[t]) begin
        if (state[t] != ST_BLOCKED) begin
          nState[t] = ST_BLOCKED;
          nBp[t]    = 1'b1;
        end
      end else begin
        case (state[t])
          ST_BLOCKED: begin
            if (occ[t] == '0) begin
              nState[t] = ST_RUN;
              nUbp[t]   = 1'b1;
            end else begin
              nState[t] = ST_UNBLOCK;
            end
          end
          ST_SQUASH: nState[t] = (occ[t] != '0) ? ST_UNBLOCK : ST_RUN;
          default: begin
            if ((occ[t] - CNT_W'(pop[t])) != '0) begin
              nState[t] = ST_BLOCKED;
            end else if (state[t] == ST_UNBLOCK) begin
              nState[t] = ST_RUN;
              nUbp[t]   = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < THREADS; t++) begin
      if (!rstN) begin
        state[t]        <= ST_IDLE;
        blockPulse[t]   <= 1'b0;
        unblockPulse[t] <= 1'b0;
      end else begin
        state[t]        <= nState[t];
        blockPulse[t]   <= nBp[t];
        unblockPulse[t] <= nUbp[t];
      end
    end
  end

  always_comb begin
    for (int t = 0; t < THREADS; t++) stateOut[t] = state[t];
  end
endmodule

// File: rtl/skid_stage.sv
module skid_stage
  import skid_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int CAP = 4,
  parameter int DATA_W = 16,
  parameter int SEQ_W = 8,
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CNT_W = $clog2(CAP) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [DATA_W-1:0]        inData,
  input  logic [SEQ_W-1:0]         inSeq,
  input  logic [TID_W-1:0]         inTid,
  input  logic                     inSquashed,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [DATA_W-1:0]        outData,
  output logic [SEQ_W-1:0]         outSeq,
  output logic [TID_W-1:0]         outTid,
  input  logic                     resFail,
  input  logic [THREADS-1:0]       stallIn,
  input  logic [THREADS-1:0]       squashIn,
  input  logic [THREADS*SEQ_W-1:0] squashSeq,
  output logic [THREADS-1:0]       blockPulse,
  output logic [THREADS-1:0]       unblockPulse,
  output logic [THREADS*3-1:0]     threadState
);
  skidStrobe_t                   strobe;
  logic [THREADS-1:0][CNT_W-1:0] occ;
  logic [CNT_W-1:0]              totalOcc;
  logic [THREADS-1:0][2:0]       stateOut;

  skid_control #(.THREADS(THREADS), .CAP(CAP), .SEQ_W(SEQ_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSeq(inSeq), .inTid(inTid),
    .inSquashed(inSquashed), .outReady(outReady), .resFail(resFail),
    .stallIn(stallIn), .squashIn(squashIn), .squashSeq(squashSeq),
    .occ(occ), .totalOcc(totalOcc), .strobe(strobe), .inReady(inReady),
    .outValid(outValid), .blockPulse(blockPulse), .unblockPulse(unblockPulse),
    .stateOut(stateOut)
  );

  skid_datapath #(.THREADS(THREADS), .CAP(CAP), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inSeq(inSeq),
    .squashSeq(squashSeq), .occ(occ), .totalOcc(totalOcc),
    .outData(outData), .outSeq(outSeq)
  );

  assign outTid      = strobe.sel[TID_W-1:0];
  assign threadState = stateOut;
endmodule

// File: rtl/skid_check.sv
module skid_check #(
  parameter int THREADS = 2,
  parameter int CAP = 4,
  parameter int TID_W = 1,
  parameter int CNT_W = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [THREADS-1:0]     stallIn,
  input logic [THREADS-1:0]     squashIn,
  input logic [THREADS-1:0]     blockPulse,
  input logic [THREADS-1:0]     unblockPulse,
  input logic [THREADS*3-1:0]   threadState,
  input logic                   outValid,
  input logic [TID_W-1:0]       outTid,
  input logic                   resFail,
  input logic [CNT_W-1:0]       totalOcc
);
  logic [2:0] selSt;
  assign selSt = threadState[outTid*3 +: 3];

  assert_capacity_R3: assert property (@(posedge clk) disable iff (!rstN)
    totalOcc <= CNT_W'(CAP));
  assert_drain_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (selSt == 3'd0 || selSt == 3'd1 || selSt == 3'd3));
  assert_resfail_R4: assert property (@(posedge clk) disable iff (!rstN)
    resFail |-> !outValid);

  for (genvar t = 0; t < THREADS; t++) begin : gThr
    logic [2:0] st;
    assign st = threadState[t*3 +: 3];

    assert_block_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
      blockPulse[t] |-> (st == 3'd2 && $past(st) != 3'd2));
    assert_stall_block_R6: assert property (@(posedge clk) disable iff (!rstN)
      (stallIn[t] && !squashIn[t]) |=> st == 3'd2);
    assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({blockPulse[t], unblockPulse[t]}));
    assert_unblock_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
      unblockPulse[t] |-> st == 3'd1);
    assert_squash_enter_R8: assert property (@(posedge clk) disable iff (!rstN)
      squashIn[t] |=> st == 3'd4);
    assert_squash_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
      (st == 3'd4 && !squashIn[t] && !stallIn[t]) |=> (st == 3'd1 || st == 3'd3));
  end
endmodule

bind skid_stage skid_check #(.THREADS(THREADS), .CAP(CAP), .TID_W(TID_W), .CNT_W(CNT_W)) uCheck (
  .clk(clk), .rstN(rstN), .stallIn(stallIn), .squashIn(squashIn),
  .blockPulse(blockPulse), .unblockPulse(unblockPulse), .threadState(threadState),
  .outValid(outValid), .outTid(outTid), .resFail(resFail), .totalOcc(totalOcc)
);

// File: tb/tb_skid_stage.sv
module tb_skid_stage;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 0, inSquashed = 0, outReady = 0, resFail = 0;
  logic        inReady, outValid;
  logic [15:0] inData = '0, outData;
  logic [7:0]  inSeq = '0, outSeq;
  logic        inTid = 0, outTid;
  logic [1:0]  stallIn = '0, squashIn = '0, blockPulse, unblockPulse;
  logic [15:0] squashSeq = '0;
  logic [5:0]  threadState;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  skid_stage dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inSeq(inSeq), .inTid(inTid), .inSquashed(inSquashed), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outSeq(outSeq), .outTid(outTid),
    .resFail(resFail), .stallIn(stallIn), .squashIn(squashIn), .squashSeq(squashSeq),
    .blockPulse(blockPulse), .unblockPulse(unblockPulse), .threadState(threadState)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(input logic v, input logic tid, input logic sq, input logic [7:0] seq);
    inValid = v; inTid = tid; inSquashed = sq; inSeq = seq; inData = {8'hA0, seq};
  endtask

  typedef struct packed {
    logic inV; logic tid; logic sq; logic [7:0] seq; logic rdy; logic [1:0] stall;
    logic eRdy; logic eOv; logic [7:0] eSeq; logic [2:0] e0; logic [2:0] e1;
    logic [1:0] eBp; logic [1:0] eUbp;
  } vec_t;

  // Per-cycle stimulus and the values expected before the following edge
  localparam vec_t VEC [13] = '{
    '{1, 0, 0, 5, 1, 0,  1, 0, 0, 0, 0, 0, 0},   // R1 reset view, push seq 5
    '{0, 0, 0, 0, 1, 0,  1, 1, 5, 0, 0, 0, 0},   // R4 drain
    '{1, 0, 0, 6, 0, 0,  1, 0, 0, 0, 0, 0, 0},
    '{1, 0, 0, 7, 0, 0,  1, 1, 6, 0, 0, 0, 0},   // withheld, leftover
    '{0, 0, 0, 0, 1, 0,  1, 0, 0, 2, 0, 0, 0},   // R5 Blocked, no pulse
    '{0, 0, 0, 0, 1, 0,  1, 1, 6, 3, 0, 0, 0},   // R7 Unblocking drains
    '{0, 0, 0, 0, 1, 0,  1, 0, 0, 2, 0, 0, 0},   // R5 leftover again
    '{0, 0, 0, 0, 1, 0,  1, 1, 7, 3, 0, 0, 0},
    '{0, 0, 0, 0, 1, 1,  1, 0, 0, 1, 0, 0, 1},   // R7 unblock pulse, R6 stall
    '{0, 0, 0, 0, 1, 1,  1, 0, 0, 2, 0, 1, 0},   // R6 block pulse once
    '{0, 0, 0, 0, 1, 0,  1, 0, 0, 2, 0, 0, 0},   // R6 no second pulse
    '{1, 1, 1, 9, 1, 0,  1, 0, 0, 1, 0, 0, 1},   // R7 empty exit, R2 offer
    '{0, 0, 0, 0, 1, 0,  1, 0, 0, 1, 0, 0, 0}    // R2 nothing stored
  };

  int seenT0, seenT1;
  int gotSeq [4];

  task automatic collect(input int cycles);
    seenT0 = 0; seenT1 = 0;
    outReady = 1;
    for (int c = 0; c < cycles; c++) begin
      #1;
      if (outValid) begin
        if (outTid == 1'b0) seenT0++;
        else begin
          if (seenT1 < 4) gotSeq[seenT1] = outSeq;
          seenT1++;
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 inReady", inReady, 1);
    check("R1 outValid", outValid, 0);
    check("R1 state", threadState, 0);
    check("R1 pulses", {blockPulse, unblockPulse}, 0);
    @(negedge clk);
    rstN = 1;

    for (int i = 0; i < 13; i++) begin
      offer(VEC[i].inV, VEC[i].tid, VEC[i].sq, VEC[i].seq);
      outReady = VEC[i].rdy; stallIn = VEC[i].stall;
      #1;
      check($sformatf("R3 row%0d inReady", i), inReady, VEC[i].eRdy);
      check($sformatf("R4 row%0d outValid", i), outValid, VEC[i].eOv);
      if (VEC[i].eOv) begin
        check($sformatf("R4 row%0d outSeq", i), outSeq, VEC[i].eSeq);
        check($sformatf("R4 row%0d outData", i), outData, {8'hA0, VEC[i].eSeq});
      end
      check($sformatf("R5 R7 row%0d state0", i), threadState[2:0], VEC[i].e0);
      check($sformatf("R9 row%0d state1", i), threadState[5:3], VEC[i].e1);
      check($sformatf("R6 row%0d blockPulse", i), blockPulse, VEC[i].eBp);
      check($sformatf("R7 row%0d unblockPulse", i), unblockPulse, VEC[i].eUbp);
      @(negedge clk);
    end

    // R3: fill the shared pool across both threads with the output withheld
    outReady = 0; stallIn = '0;
    offer(1, 0, 0, 10); @(negedge clk);
    offer(1, 0, 0, 11); @(negedge clk);
    offer(1, 1, 0, 20); @(negedge clk);
    offer(1, 1, 0, 21);
    #1 check("R3 one slot left", inReady, 1);
    @(negedge clk);
    offer(1, 1, 0, 99);
    #1 check("R3 pool full", inReady, 0);
    @(negedge clk);
    offer(0, 0, 0, 0);

    // R8: thread 0 bound 9 empties it, thread 1 bound 20 stops at its head
    squashIn = 2'b11; squashSeq = {8'd20, 8'd9};
    @(negedge clk);
    squashIn = '0;
    #1;
    check("R8 thread0 Squashing", threadState[2:0], 4);
    check("R8 thread1 Squashing", threadState[5:3], 4);
    check("R8 two freed", inReady, 1);
    @(negedge clk);
    #1;
    check("R9 empty to Running", threadState[2:0], 1);
    check("R9 nonempty to Unblocking", threadState[5:3], 3);
    @(negedge clk);
    collect(20);
    check("R8 flushed thread silent", seenT0, 0);
    check("R8 kept entries", seenT1, 2);
    check("R8 first kept seq", gotSeq[0], 20);
    check("R4 fifo order seq", gotSeq[1], 21);

    // R4: a failed resource request suppresses the output
    outReady = 0;
    offer(1, 0, 0, 30); @(negedge clk);
    offer(0, 0, 0, 0);
    outReady = 1; resFail = 1;
    #1 check("R4 resFail blocks output", outValid, 0);
    @(negedge clk);
    resFail = 0;
    collect(12);
    check("R4 held entry sent later", seenT0, 1);
    check("R4 nothing else", seenT1, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule